// File: doc/BRIEF.md
# Staged Reset Release Generator

This block takes one raw active-low reset and turns it into two derived active-low resets for a single clock domain. Both derived resets drop together, without waiting for a clock, as soon as the raw reset is driven low. They come back out of reset in two steps. The first stage releases after a short synchronizer delay, and this frees the logic that initializes the device. The second stage waits for that logic to report that it has finished.

An optional timeout limit sets how long the second stage may wait. If the completion indication never arrives within the limit, the limit forces the release and raises an error flag. The flag stays set until the next raw reset. Driving the raw reset low at any point in the sequence puts both outputs back into reset, and the sequence then runs again from the beginning.

Top module: `stg_rst_gen`

## Requirements
- R1: While `rst_a_ni` is low, `rst_stage1_no`, `rst_stage2_no` and `init_err_o` are all 0. A falling `rst_a_ni` forces all three low at once, with no clock edge needed.
- R2: With default parameters, `rst_stage1_no` goes to 1 on the second rising clock edge after `rst_a_ni` goes high.
- R3: `init_done_i` has no effect while `rst_stage1_no` is 0. A one-cycle pulse seen only before that release never frees the second stage.
- R4: `rst_stage2_no` goes to 1 on the first rising edge at which both `init_done_i` and `rst_stage1_no` are sampled 1. This holds whether `init_done_i` is a held level or a one-cycle pulse.
- R5: `rst_stage2_no` is never 1 while `rst_stage1_no` is 0. Its release always falls on a later edge than the stage-1 release.
- R6: With `to_limit_i` = L and L ≠ 0, if no completion arrives in time, `rst_stage2_no` goes to 1 on the L-th edge that samples `rst_stage1_no` as 1. `init_err_o` rises on that same edge. L = 0 turns the timeout off.
- R7: If completion and the timeout fall on the same edge, the release counts as a completion and `init_err_o` stays 0.
- R8: Once set, `init_err_o` and a released `rst_stage2_no` stay at 1 until `rst_a_ni` goes low, whatever `init_done_i` does.
- R9: Driving `rst_a_ni` low in the middle of the sequence restarts it. After the next release, stage 1 again releases on the second edge and stage 2 waits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_a_ni | input | 1 | Raw asynchronous reset, active low |
| init_done_i | input | 1 | Initialization complete (level or one-cycle pulse) |
| to_limit_i | input | TO_W | Timeout in edges after the stage-1 release; 0 turns it off |
| rst_stage1_no | output | 1 | First staged reset, active low |
| rst_stage2_no | output | 1 | Second staged reset, active low |
| init_err_o | output | 1 | Sticky flag showing that the timeout released stage 2 |

## Verification
Edges are counted from the raw release, with that release driven at a falling edge. Stage 1 is due at edge 2. A completion sampled at edge E ≥ 3 releases stage 2 at edge E, and a timeout of L releases it at edge 2 + L. The bench samples 1 ns after every rising edge and records the first edge at which each output reads 1. It compares those edge numbers, and the error flag, against table values worked out from these rules. The asynchronous cases drive the raw reset low halfway through a cycle and check the outputs before the next edge arrives.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,   // stage 1 still held
      ST_WAIT = 2'd1,   // waiting for completion or timeout
      ST_RUN  = 2'd2    // stage 2 released
   } stage_e;
endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_ni,
   output logic rel_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("rsg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rel_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsg_timeout.sv
module rsg_timeout #(
   parameter int unsigned TO_W = 8
) (
   input  logic            clk_i,
   input  logic            arst_ni,
   input  logic            count_en_i,
   input  logic [TO_W-1:0] limit_i,
   output logic            hit_o
);
   if (TO_W < 1) begin : g_bad_width
      $error("rsg_timeout: TO_W must be at least 1");
   end

   logic [TO_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni)        cnt_q <= '0;
      else if (count_en_i) cnt_q <= cnt_q + 1'b1;
   end

   assign hit_o = (limit_i != '0) && (cnt_q == TO_W'(limit_i - 1'b1));

   // R6
   cnt_below_limit_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (count_en_i && limit_i != '0) |-> (cnt_q < limit_i));
endmodule

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
   import rsg_pkg::*;
(
   input  logic clk_i,
   input  logic arst_ni,
   input  logic stage1_rel_i,
   input  logic init_done_i,
   input  logic tmo_hit_i,
   output logic count_en_o,
   output logic stage2_rel_o,
   output logic err_o
);
   stage_e st_q, st_d;
   logic   err_d;

   always_comb begin
      st_d  = st_q;
      err_d = 1'b0;
      if (st_q != ST_RUN && stage1_rel_i) begin
         if (init_done_i) begin
            st_d = ST_RUN;
         end else if (tmo_hit_i) begin
            st_d  = ST_RUN;
            err_d = 1'b1;
         end else begin
            st_d = ST_WAIT;
         end
      end
   end

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         st_q  <= ST_HOLD;
         err_o <= 1'b0;
      end else begin
         st_q  <= st_d;
         err_o <= err_o | err_d;
      end
   end

   assign count_en_o   = stage1_rel_i && (st_q != ST_RUN);
   assign stage2_rel_o = (st_q == ST_RUN);

   // R3
   release_after_stage1_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
      $rose(stage2_rel_o) |-> $past(stage1_rel_i));
   // R6
   err_with_release_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
      $rose(err_o) |-> $rose(stage2_rel_o));
   // R8
   err_sticky_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
      err_o |=> err_o);
   // R8
   stage2_held_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
      stage2_rel_o |=> stage2_rel_o);
endmodule

// File: rtl/stg_rst_gen.sv
module stg_rst_gen #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TIMEOUT_EN  = 1'b1,
   parameter int unsigned TO_W        = 8
) (
   input  logic            clk_i,
   input  logic            rst_a_ni,
   input  logic            init_done_i,
   input  logic [TO_W-1:0] to_limit_i,
   output logic            rst_stage1_no,
   output logic            rst_stage2_no,
   output logic            init_err_o
);
   localparam int unsigned EDGE_MAX = SYNC_STAGES + 1;
   localparam int unsigned EDGE_W   = $clog2(EDGE_MAX + 1);

   logic stage1_rel, count_en, tmo_hit, stage2_rel, err;

   rsg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .arst_ni (rst_a_ni),
      .rel_o   (stage1_rel)
   );

   if (TIMEOUT_EN) begin : g_tmo
      rsg_timeout #(.TO_W(TO_W)) u_tmo (
         .clk_i      (clk_i),
         .arst_ni    (rst_a_ni),
         .count_en_i (count_en),
         .limit_i    (to_limit_i),
         .hit_o      (tmo_hit)
      );
   end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
   end

   rsg_ctrl u_ctrl (
      .clk_i        (clk_i),
      .arst_ni      (rst_a_ni),
      .stage1_rel_i (stage1_rel),
      .init_done_i  (init_done_i),
      .tmo_hit_i    (tmo_hit),
      .count_en_o   (count_en),
      .stage2_rel_o (stage2_rel),
      .err_o        (err)
   );

   assign rst_stage1_no = stage1_rel;
   assign rst_stage2_no = stage2_rel;
   assign init_err_o    = err;

   // edges seen since the raw release, saturating; used by the check below
   logic [EDGE_W-1:0] edges_q;
   always_ff @(posedge clk_i or negedge rst_a_ni) begin
      if (!rst_a_ni)                     edges_q <= '0;
      else if (edges_q != EDGE_W'(EDGE_MAX)) edges_q <= edges_q + 1'b1;
   end

   // R2
   stage1_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_a_ni)
      $rose(rst_stage1_no) |-> (edges_q == EDGE_W'(SYNC_STAGES)));
   // R5
   stage_order_chk: assert property (@(posedge clk_i) disable iff (!rst_a_ni)
      !rst_stage1_no |-> !rst_stage2_no);
endmodule

// File: tb/stg_rst_gen_tb.sv
`timescale 1ns/100ps
module stg_rst_gen_tb;
   logic       clk_i = 1'b0;
   logic       rst_a_ni = 1'b0;
   logic       init_done_i = 1'b0;
   logic [7:0] to_limit_i = 8'd0;
   logic       rst_stage1_no, rst_stage2_no, init_err_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk_i = ~clk_i;

   stg_rst_gen u_dut (
      .clk_i         (clk_i),
      .rst_a_ni      (rst_a_ni),
      .init_done_i   (init_done_i),
      .to_limit_i    (to_limit_i),
      .rst_stage1_no (rst_stage1_no),
      .rst_stage2_no (rst_stage2_no),
      .init_err_o    (init_err_o)
   );

   typedef struct packed {
      logic [7:0] done_edge;  // 0: never
      logic       pulse;      // 1: high only before done_edge; 0: level from done_edge on
      logic [7:0] limit;
      logic [7:0] exp2;       // edge of stage-2 release, 0: none in window
      logic       experr;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{8'd1, 1'b0, 8'd0, 8'd3, 1'b0},  // level held from start, R3/R4
      '{8'd2, 1'b1, 8'd0, 8'd0, 1'b0},  // pulse while stage1 held, R3
      '{8'd6, 1'b1, 8'd0, 8'd6, 1'b0},  // pulse, R4
      '{8'd0, 1'b0, 8'd5, 8'd7, 1'b1},  // timeout, R6
      '{8'd6, 1'b1, 8'd5, 8'd6, 1'b0},  // done before timeout, R4
      '{8'd7, 1'b1, 8'd5, 8'd7, 1'b0},  // same edge, R7
      '{8'd0, 1'b0, 8'd1, 8'd3, 1'b1},  // shortest timeout, R6
      '{8'd2, 1'b1, 8'd4, 8'd6, 1'b1}   // ignored pulse then timeout, R3/R6
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // assumes the caller stands at a negedge; returns first release edges
   task automatic run_seq(input vec_t v, input int edges, output int e1, output int e2);
      e1 = 0;
      e2 = 0;
      rst_a_ni = 1'b1;
      for (int k = 1; k <= edges; k++) begin
         if (v.pulse) init_done_i = (k == int'(v.done_edge));
         else if (v.done_edge != 0 && k >= int'(v.done_edge)) init_done_i = 1'b1;
         @(posedge clk_i); #1;
         if (rst_stage1_no && e1 == 0) e1 = k;
         if (rst_stage2_no && e2 == 0) e2 = k;
         @(negedge clk_i);
      end
   endtask

   task automatic enter_reset(input logic [7:0] lim);
      rst_a_ni    = 1'b0;
      init_done_i = 1'b0;
      to_limit_i  = lim;
      repeat (2) @(negedge clk_i);
      check(!rst_stage1_no && !rst_stage2_no && !init_err_o, "R1 outputs in reset",
            {rst_stage1_no, rst_stage2_no, init_err_o}, 0);
   endtask

   initial begin
      int e1, e2;
      vec_t nodone;
      nodone = '{8'd0, 1'b0, 8'd0, 8'd0, 1'b0};
      #1;
      check(!rst_stage1_no && !rst_stage2_no && !init_err_o, "R1 time zero",
            {rst_stage1_no, rst_stage2_no, init_err_o}, 0);
      @(negedge clk_i);

      for (int i = 0; i < NV; i++) begin
         enter_reset(VECS[i].limit);
         run_seq(VECS[i], 40, e1, e2);
         check(e1 == 2, "R2 stage1 release edge", e1, 2);
         check(e2 == int'(VECS[i].exp2), "R4/R6 stage2 release edge (R3 R7)", e2, int'(VECS[i].exp2));
         check(init_err_o == VECS[i].experr, "R6/R7 error flag", init_err_o, VECS[i].experr);
         check(e2 == 0 || e2 > e1, "R5 order", e2, e1 + 1);
      end

      // R8: sticky flag after timeout, completion afterwards changes nothing
      enter_reset(8'd3);
      run_seq(nodone, 10, e1, e2);
      check(e2 == 5 && init_err_o, "R6 timeout of 3", e2, 5);
      init_done_i = 1'b1;
      repeat (3) @(negedge clk_i);
      init_done_i = 1'b0;
      repeat (3) @(negedge clk_i);
      check(init_err_o == 1'b1, "R8 error sticky", init_err_o, 1);
      check(rst_stage2_no == 1'b1, "R8 stage2 stays released", rst_stage2_no, 1);

      // R1: asynchronous assertion while both released, mid high phase
      @(posedge clk_i); #1;
      rst_a_ni = 1'b0;
      #0.5;
      check(!rst_stage1_no && !rst_stage2_no && !init_err_o, "R1 async assert",
            {rst_stage1_no, rst_stage2_no, init_err_o}, 0);
      @(negedge clk_i);

      // R9: reassert after stage1 release, before stage2
      enter_reset(8'd0);
      run_seq(nodone, 4, e1, e2);
      check(e1 == 2 && e2 == 0, "R9 mid-sequence state", e1, 2);
      @(posedge clk_i); #1;
      rst_a_ni = 1'b0;
      #0.5;
      check(!rst_stage1_no && !rst_stage2_no, "R9 reassert drops outputs",
            {rst_stage1_no, rst_stage2_no}, 0);
      @(negedge clk_i);
      @(negedge clk_i);
      run_seq('{8'd5, 1'b1, 8'd0, 8'd5, 1'b0}, 8, e1, e2);
      check(e1 == 2, "R9 restart stage1 edge", e1, 2);
      check(e2 == 5, "R9 restart stage2 edge", e2, 5);

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule